// File: doc/BRIEF.md
# Fractional multiplier with output shift

This block is a pipelined signed fractional multiply unit for a fixed-point DSP datapath. Each transaction carries two two's complement fractional operands and a small shift code. The block forms the full double-width product, moves that whole product left or right by the distance the code selects, and only then cuts out the result word. A left shift therefore brings low-order product bits up into the result instead of filling with zeros. Bits that leave the top are dropped, so the result wraps. The compiler is expected to have proven that the true value fits the narrower integer range.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream. The two register stages, product and output, advance together as one unit. They move whenever the output register is empty or the consumer is accepting. When the consumer holds `out_ready` low while a result is waiting, the output word is frozen and `in_ready` drops in the same cycle. No transaction is lost or duplicated. The parameter `SHIFT_CODES` (2, 4 or 8) selects the set of shift distances and the width of the code field.

Top module: `frac_shift_mul`

## Requirements
- R1: With a shift of zero, `out_data` equals bits [2W-2:W-1] of the 2W-bit signed product, where W is `DATA_W`. This is a truncated Q(W-1) multiply.
- R2: A left shift of L is applied to the full product before extraction, so `out_data` equals bits [2W-2-L:W-1-L] of the product. Upper bits are discarded without saturation.
- R3: A right shift of R is arithmetic on the full product. `out_data` equals bits [2W-2+R:W-1+R] of the sign-extended product, truncated toward minus infinity with no rounding.
- R4: With `SHIFT_CODES`=8, a 3-bit code 0..7 selects, in ascending order, left 4, 3, 2, 1, none, then right 1, 2, 3.
- R5: With `SHIFT_CODES`=4, a 2-bit code 0..3 selects left 2, left 1, none, right 1.
- R6: With `SHIFT_CODES`=2, a 1-bit code selects left 1 (code 0) or no shift (code 1).
- R7: Multiplying the most negative code by itself with no shift yields the most negative code (wrap, no saturation).
- R8: When the output is not stalled, a transaction accepted on the input appears on the output exactly two cycles later. At most two transactions are ever in flight.
- R9: A synchronous active-high reset clears both stage valid flags, so `out_valid` is 0 in the first cycle after reset.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold on the next cycle, and `in_ready` is 0. Otherwise `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair and shift code are valid |
| in_ready | output | 1 | Unit accepts a transaction this cycle |
| in_a | input | DATA_W | Multiplicand, signed fraction |
| in_b | input | DATA_W | Multiplier, signed fraction |
| in_shift | input | $clog2(SHIFT_CODES) | Shift code, 0 = most left |
| out_valid | output | 1 | Result word is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | DATA_W | Shifted, truncated signed result |

## Verification
The bench builds three copies of the unit. The first uses `DATA_W`=6 with eight shift codes and the second uses `DATA_W`=5 with four codes. At these widths every operand pair under every shift code can be swept, which covers every sign combination, both wrap directions and the most-negative square. The four-code copy runs under a repeating consumer stall, which exercises the frozen output and the dropped `in_ready`. The third copy keeps the full 16-bit width with two codes and checks directed Q15 cases, including low-bit recovery on the one-left shift.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;

  // Largest left shift supported by a code set of the given size.
  function automatic int left_limit(input int codes);
    return codes / 2;
  endfunction

  // Signed shift distance for a code: positive is left, negative is right.
  function automatic int shift_for_code(input int codes, input int code);
    return left_limit(codes) - code;
  endfunction

endpackage

// File: rtl/frac_product_stage.sv
module frac_product_stage #(
  parameter int W  = 16,
  parameter int CW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            in_valid,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [CW-1:0]   in_code,
  output logic            p_valid,
  output logic [2*W-1:0]  p_prod,
  output logic [CW-1:0]   p_code
);
  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;
  logic [PW-1:0] prod_c;

  // Sign-extend both operands; the low PW bits of the unsigned product
  // equal the signed product.
  assign a_ext  = {{W{in_a[W-1]}}, in_a};
  assign b_ext  = {{W{in_b[W-1]}}, in_b};
  assign prod_c = a_ext * b_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
    end else if (adv) begin
      p_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      p_prod <= prod_c;
      p_code <= in_code;
    end
  end

endmodule

// File: rtl/frac_align_extract.sv
module frac_align_extract #(
  parameter int W     = 16,
  parameter int CODES = 8,
  parameter int CW    = 3
) (
  input  logic [2*W-1:0] prod,
  input  logic [CW-1:0]  code,
  output logic [W-1:0]   result
);
  localparam int PW = 2 * W;

  logic [W-1:0] cand [CODES];

  // One candidate word per shift code, each cut from the full product.
  for (genvar k = 0; k < CODES; k++) begin : g_cand
    localparam int SH = frac_mul_pkg::shift_for_code(CODES, k);
    if (SH >= 0) begin : g_left
      logic [PW-1:0] moved;
      assign moved    = (prod << SH) >> (W - 1);
      assign cand[k]  = moved[W-1:0];
    end else begin : g_right
      logic signed [PW-1:0] moved;
      assign moved    = $signed(prod) >>> (W - 1 - SH);
      assign cand[k]  = moved[W-1:0];
    end
  end

  assign result = cand[code];

endmodule

// File: rtl/frac_output_stage.sv
module frac_output_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         d_valid,
  input  logic [W-1:0] d_word,
  output logic         q_valid,
  output logic [W-1:0] q_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (adv) begin
      q_valid <= d_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      q_word <= d_word;
    end
  end

endmodule

// File: rtl/frac_shift_mul.sv
module frac_shift_mul #(
  parameter int DATA_W      = 16,
  parameter int SHIFT_CODES = 8,
  localparam int CODE_W     = (SHIFT_CODES > 1) ? $clog2(SHIFT_CODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [CODE_W-1:0] in_shift,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic                adv;
  logic                p_valid;
  logic [2*DATA_W-1:0] p_prod;
  logic [CODE_W-1:0]   p_code;
  logic [DATA_W-1:0]   aligned;

  // Both stages move together; they stall only when a result waits unread.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  frac_product_stage #(.W(DATA_W), .CW(CODE_W)) u_prod (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_code  (in_shift),
    .p_valid  (p_valid),
    .p_prod   (p_prod),
    .p_code   (p_code)
  );

  frac_align_extract #(.W(DATA_W), .CODES(SHIFT_CODES), .CW(CODE_W)) u_align (
    .prod   (p_prod),
    .code   (p_code),
    .result (aligned)
  );

  frac_output_stage #(.W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .d_valid (p_valid),
    .d_word  (aligned),
    .q_valid (out_valid),
    .q_word  (out_data)
  );

endmodule

// File: rtl/frac_shift_mul_chk.sv
module frac_shift_mul_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);

  logic [2:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= 3'd0;
    end else begin
      inflight <= inflight + {2'b00, in_valid && in_ready} - {2'b00, out_valid && out_ready};
    end
  end

  // R8: never more than two transactions between input and output
  assert_inflight_R8: assert property (@(posedge clk) disable iff (rst)
    inflight <= 3'd2);

  // R8: a valid output always belongs to an accepted input
  assert_out_has_source_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight != 3'd0);

  // R9: output empty right after reset
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  // R10: stalled result is held
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: input refused only while a result waits
  assert_ready_R10: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

endmodule

bind frac_shift_mul frac_shift_mul_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_frac_shift_mul.sv
module tb_frac_shift_mul;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // eight codes, 6-bit data
  logic       v8 = 0, rdy8, ov8, r8 = 1;
  logic [5:0] a8 = 0, b8 = 0, od8;
  logic [2:0] s8 = 0;
  // four codes, 5-bit data
  logic       v4 = 0, rdy4, ov4, r4 = 1;
  logic [4:0] a4 = 0, b4 = 0, od4;
  logic [1:0] s4 = 0;
  // two codes, 16-bit data
  logic        v2 = 0, rdy2, ov2, r2 = 1;
  logic [15:0] a2 = 0, b2 = 0, od2;
  logic [0:0]  s2 = 0;

  frac_shift_mul #(.DATA_W(6), .SHIFT_CODES(8)) dut (
    .clk(clk), .rst(rst), .in_valid(v8), .in_ready(rdy8), .in_a(a8), .in_b(b8),
    .in_shift(s8), .out_valid(ov8), .out_ready(r8), .out_data(od8));

  frac_shift_mul #(.DATA_W(5), .SHIFT_CODES(4)) dut_c4 (
    .clk(clk), .rst(rst), .in_valid(v4), .in_ready(rdy4), .in_a(a4), .in_b(b4),
    .in_shift(s4), .out_valid(ov4), .out_ready(r4), .out_data(od4));

  frac_shift_mul #(.DATA_W(16), .SHIFT_CODES(2)) dut_c2 (
    .clk(clk), .rst(rst), .in_valid(v2), .in_ready(rdy2), .in_a(a2), .in_b(b2),
    .in_shift(s2), .out_valid(ov2), .out_ready(r2), .out_data(od2));

  // floor(a*b*2^L / 2^(w-1)) modulo 2^w
  function automatic logic [15:0] model(longint a, longint b, int code, int w, int c);
    longint p;
    longint s;
    int     l;
    p = a * b;
    l = c / 2 - code;
    if (l >= 0) s = p <<< l;
    else        s = p >>> (-l);
    s = s >>> (w - 1);
    return 16'(s & ((64'sd1 <<< w) - 1));
  endfunction

  function automatic string tag_for(int l, string map);
    if (l > 0)      return {"R2 ", map};
    else if (l < 0) return {"R3 ", map};
    return {"R1 ", map};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [15:0] q8_exp[$];
  string       q8_tag[$];
  int          q8_cyc[$];
  logic [15:0] q4_exp[$];
  string       q4_tag[$];
  logic [15:0] q2_exp[$];
  string       q2_tag[$];

  function automatic logic stall_pat(int n);
    return (n % 7) < 5;
  endfunction

  task automatic send8(input int ia, input int ib, input int code);
    @(negedge clk);
    a8 = 6'(ia); b8 = 6'(ib); s8 = 3'(code); v8 = 1'b1;
    #1;
    while (!rdy8) begin @(negedge clk); #1; end
    q8_exp.push_back(model(ia, ib, code, 6, 8));
    q8_tag.push_back(tag_for(4 - code, "R4"));
    q8_cyc.push_back(cyc);
  endtask

  task automatic send4(input int ia, input int ib, input int code);
    @(negedge clk);
    r4 = stall_pat(cyc);
    a4 = 5'(ia); b4 = 5'(ib); s4 = 2'(code); v4 = 1'b1;
    #1;
    while (!rdy4) begin @(negedge clk); r4 = stall_pat(cyc); #1; end
    q4_exp.push_back(model(ia, ib, code, 5, 4));
    q4_tag.push_back(tag_for(2 - code, "R5"));
  endtask

  task automatic send2(input int ia, input int ib, input int code, input string tag);
    @(negedge clk);
    a2 = 16'(ia); b2 = 16'(ib); s2 = 1'(code); v2 = 1'b1;
    #1;
    while (!rdy2) begin @(negedge clk); #1; end
    q2_exp.push_back(model(ia, ib, code, 16, 2));
    q2_tag.push_back(tag);
  endtask

  // monitors sample 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (!rst && ov8 && r8) begin
      if (q8_exp.size() == 0) chk(1'b0, "R8 unexpected output", {10'b0, od8}, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        int st;
        e = q8_exp.pop_front(); t = q8_tag.pop_front(); st = q8_cyc.pop_front();
        chk({10'b0, od8} == e, t, {10'b0, od8}, e);
        chk(cyc - st == 2, "R8 latency", 16'(cyc - st), 16'd2);
      end
    end
  end

  logic        held4 = 1'b0;
  logic [4:0]  held4_d = '0;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (held4) chk(ov4 && od4 == held4_d, "R10 hold", {10'b0, ov4, od4}, {10'b0, 1'b1, held4_d});
      chk(rdy4 == !(ov4 && !r4), "R10 in_ready", {15'b0, rdy4}, {15'b0, !(ov4 && !r4)});
      held4   = ov4 && !r4;
      held4_d = od4;
      if (ov4 && r4) begin
        if (q4_exp.size() == 0) chk(1'b0, "R10 unexpected output", {11'b0, od4}, 16'h0);
        else begin
          logic [15:0] e;
          string t;
          e = q4_exp.pop_front(); t = q4_tag.pop_front();
          chk({11'b0, od4} == e, t, {11'b0, od4}, e);
        end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (!rst && ov2 && r2) begin
      if (q2_exp.size() == 0) chk(1'b0, "R6 unexpected output", od2, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = q2_exp.pop_front(); t = q2_tag.pop_front();
        chk(od2 == e, t, od2, e);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(!ov8 && !ov4 && !ov2, "R9 out_valid after reset", {13'b0, ov8, ov4, ov2}, 16'h0);
    chk(rdy8 && rdy4 && rdy2, "R9 in_ready after reset", {13'b0, rdy8, rdy4, rdy2}, 16'h7);

    // eight-code sweep, unstalled
    for (int ia = -32; ia < 32; ia++)
      for (int ib = -32; ib < 32; ib++)
        for (int c = 0; c < 8; c++) send8(ia, ib, c);
    @(negedge clk); v8 = 1'b0;
    repeat (6) @(negedge clk);

    // four-code sweep under consumer stalls
    for (int ia = -16; ia < 16; ia++)
      for (int ib = -16; ib < 16; ib++)
        for (int c = 0; c < 4; c++) send4(ia, ib, c);
    @(negedge clk); v4 = 1'b0;
    repeat (12) @(negedge clk) r4 = 1'b1;

    // two-code directed Q15 cases
    send2(-32768, -32768, 1, "R7 R6 min squared");
    send2(16384, 16384, 1, "R1 R6 half squared");
    send2(16384, 16384, 0, "R2 R6 half squared left");
    send2(1, 16384, 1, "R1 R6 low bits truncated");
    send2(1, 16384, 0, "R2 R6 low bit recovered");
    send2(32767, 32767, 0, "R2 R6 wrap on left");
    send2(-3, 5, 1, "R1 R6 negative truncation");
    for (int i = 0; i < 64; i++) begin
      send2(i * 1021 - 32768, 32767 - i * 977, i % 2, "R6 sweep");
    end
    @(negedge clk); v2 = 1'b0;
    repeat (6) @(negedge clk);

    chk(q8_exp.size() == 0 && q4_exp.size() == 0 && q2_exp.size() == 0,
        "R8 all results delivered", 16'(q8_exp.size() + q4_exp.size() + q2_exp.size()), 16'h0);
    finish_run();
  end

endmodule